// File: doc/BRIEF.md
# Floating-Point Rounding Unit

This block takes one unrounded result in the wide internal format and rounds it to a selected significand width. The incoming item carries a sign, a 15-bit biased exponent (bias 16383), a normalized 64-bit significand and three extra bits below it: guard, round and sticky. Two 2-bit control fields are sampled with each item. One picks the rounding direction and the other picks how many significand bits survive. The rounded item leaves with its sign, exponent and significand. Four flags go with it: inexact, rounded-up, overflow and underflow.

Items enter and leave through valid/ready handshakes. An item is accepted in a cycle where `in_valid` and `in_ready` are both high, and its rounded result is presented on the next clock. `in_ready` is high when the output register is empty, or when it is being drained in that same cycle. A full output register that is not drained refuses new items, and its contents stay frozen until `out_ready` is seen. The control fields and the item fields are only meaningful in an accepting cycle.

Top module: `fpr_round_unit`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A result appears on the output one clock after its item is accepted. While `out_valid` is high and `out_ready` is low, every output stays unchanged. Results leave in acceptance order.
- R2: `prec_sel` 2'b00 keeps 24 significand bits, so `out_sig[39:0]` is zero. 2'b10 keeps 53 bits, so `out_sig[10:0]` is zero. 2'b11 keeps all 64 bits, and the unused code 2'b01 also keeps 64 bits.
- R3: `rnd_mode` 2'b00 is round to nearest. A discarded part above half a unit of the last kept place rounds up and one below half rounds down. An exact half rounds to the neighbour whose last kept bit is 0.
- R4: `rnd_mode` 2'b01 (toward minus infinity) increments the magnitude only when `in_sign` is 1 and the value is inexact. 2'b10 (toward plus infinity) does so only when `in_sign` is 0 and the value is inexact. 2'b11 (toward zero) never increments.
- R5: `out_inexact` is 1 exactly when any discarded significand bit, or any of guard, round and sticky, is 1.
- R6: `out_rnd_up` is 1 exactly when rounding increased the magnitude. It is never 1 without `out_inexact`.
- R7: When the increment carries out of the kept field, the significand becomes 1 followed by zeros and the exponent goes up by one. Every nonzero output significand has bit 63 set.
- R8: `out_ovf` is 1 exactly when a rounding carry brings the exponent to 15'h7FFF.
- R9: `out_unf` is 1 exactly when the output exponent is 0 and the output significand is nonzero.
- R10: `out_sign` equals the accepted sign. After reset `out_valid` is 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Item offered |
| in_ready | output | 1 | Item can be taken this cycle |
| in_sign | input | 1 | Sign of the item |
| in_exp | input | 15 | Biased exponent of the item |
| in_sig | input | 64 | Significand, bit 63 set for nonzero items |
| in_grd | input | 1 | First bit below the significand |
| in_rnd | input | 1 | Second bit below the significand |
| in_stk | input | 1 | OR of all lower bits |
| rnd_mode | input | 2 | Rounding direction code |
| prec_sel | input | 2 | Kept-width code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Result biased exponent |
| out_sig | output | 64 | Rounded significand |
| out_inexact | output | 1 | Some discarded bit was nonzero |
| out_rnd_up | output | 1 | Magnitude was incremented |
| out_ovf | output | 1 | Carry pushed exponent to all ones |
| out_unf | output | 1 | Nonzero result with zero exponent |

## Verification
The renormalizing carry and the overflow flag come from the same increment, so they can occur in one result. Items whose kept field is all ones are fed at exponent 15'h7FFE in every direction that rounds up. The expected shifted significand, the incremented exponent and the flag are judged together against a behavioural model. That model works on the full discarded remainder compared with a half unit, not on separate round and sticky bits. A second overlap is a stalled output and a new item in flight: with random `out_ready`, frozen outputs are checked while queued items wait, and items accepted in the same cycle that the register drains are checked too.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_TO_NEG    = 2'b01,
    RND_TO_POS    = 2'b10,
    RND_TO_ZERO   = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    PREC_SHORT  = 2'b00,
    PREC_SPARE  = 2'b01,
    PREC_MEDIUM = 2'b10,
    PREC_FULL   = 2'b11
  } prec_sel_e;

  typedef struct packed {
    logic inexact;
    logic rnd_up;
    logic ovf;
    logic unf;
  } rnd_flags_t;

endpackage

// File: rtl/fpr_discard_split.sv
module fpr_discard_split
  import fpr_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int P_SGL = 24,
  parameter int P_DBL = 53
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             grd,
  input  logic             rnd,
  input  logic             stk,
  input  prec_sel_e        prec,
  output logic [SIG_W-1:0] kept,
  output logic [SIG_W-1:0] unit,
  output logic             rbit,
  output logic             sbit,
  output logic             lbit
);
  localparam int NVAR = 3;

  logic [SIG_W-1:0] mask_v [NVAR];
  logic [SIG_W-1:0] unit_v [NVAR];
  logic             rb_v   [NVAR];
  logic             st_v   [NVAR];
  logic             lb_v   [NVAR];

  for (genvar k = 0; k < NVAR; k++) begin : g_width
    localparam int KW   = (k == 0) ? P_SGL : ((k == 1) ? P_DBL : SIG_W);
    localparam int DROP = SIG_W - KW;
    if (DROP == 0) begin : g_none
      assign mask_v[k] = '1;
      assign unit_v[k] = SIG_W'(1);
      assign rb_v[k]   = grd;
      assign st_v[k]   = rnd | stk;
      assign lb_v[k]   = sig[0];
    end else begin : g_some
      assign mask_v[k] = ~((SIG_W'(1) << DROP) - SIG_W'(1));
      assign unit_v[k] = SIG_W'(1) << DROP;
      assign rb_v[k]   = sig[DROP-1];
      assign lb_v[k]   = sig[DROP];
      if (DROP == 1) begin : g_one
        assign st_v[k] = grd | rnd | stk;
      end else begin : g_many
        assign st_v[k] = (|sig[DROP-2:0]) | grd | rnd | stk;
      end
    end
  end

  always_comb begin
    case (prec)
      PREC_SHORT: begin
        kept = sig & mask_v[0]; unit = unit_v[0];
        rbit = rb_v[0]; sbit = st_v[0]; lbit = lb_v[0];
      end
      PREC_MEDIUM: begin
        kept = sig & mask_v[1]; unit = unit_v[1];
        rbit = rb_v[1]; sbit = st_v[1]; lbit = lb_v[1];
      end
      default: begin
        kept = sig & mask_v[2]; unit = unit_v[2];
        rbit = rb_v[2]; sbit = st_v[2]; lbit = lb_v[2];
      end
    endcase
  end

endmodule

// File: rtl/fpr_round_decide.sv
module fpr_round_decide
  import fpr_pkg::*;
(
  input  rnd_mode_e mode,
  input  logic      sign,
  input  logic      rbit,
  input  logic      sbit,
  input  logic      lbit,
  output logic      do_inc,
  output logic      inexact
);
  assign inexact = rbit | sbit;

  always_comb begin
    case (mode)
      RND_NEAR_EVEN: do_inc = rbit & (sbit | lbit);
      RND_TO_NEG:    do_inc = sign & inexact;
      RND_TO_POS:    do_inc = ~sign & inexact;
      default:       do_inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpr_incr_norm.sv
module fpr_incr_norm #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15
) (
  input  logic [SIG_W-1:0] kept,
  input  logic [SIG_W-1:0] unit,
  input  logic             do_inc,
  input  logic [EXP_W-1:0] exp_in,
  output logic [SIG_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             ovf,
  output logic             unf
);
  logic [SIG_W:0] sum;
  logic           carry;

  assign sum   = {1'b0, kept} + ({1'b0, unit} & {(SIG_W+1){do_inc}});
  assign carry = sum[SIG_W];

  always_comb begin
    if (carry) begin
      sig_o = {1'b1, {(SIG_W-1){1'b0}}};
      exp_o = exp_in + EXP_W'(1);
    end else begin
      sig_o = sum[SIG_W-1:0];
      exp_o = exp_in;
    end
  end

  assign ovf = carry & (&exp_o);
  assign unf = (exp_o == '0) & (|sig_o);

endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
  import fpr_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15,
  parameter int P_SGL = 24,
  parameter int P_DBL = 53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0] in_sig,
  input  logic             in_grd,
  input  logic             in_rnd,
  input  logic             in_stk,
  input  logic [1:0]       rnd_mode,
  input  logic [1:0]       prec_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [SIG_W-1:0] out_sig,
  output logic             out_inexact,
  output logic             out_rnd_up,
  output logic             out_ovf,
  output logic             out_unf
);
  logic             accept;
  logic [SIG_W-1:0] kept, unit, sig_n;
  logic [EXP_W-1:0] exp_n;
  logic             rbit, sbit, lbit, do_inc, inexact, ovf_n, unf_n;
  rnd_flags_t       flags_n, flags_q;

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  fpr_discard_split #(.SIG_W(SIG_W), .P_SGL(P_SGL), .P_DBL(P_DBL)) u_split (
    .sig  (in_sig),
    .grd  (in_grd),
    .rnd  (in_rnd),
    .stk  (in_stk),
    .prec (prec_sel_e'(prec_sel)),
    .kept (kept),
    .unit (unit),
    .rbit (rbit),
    .sbit (sbit),
    .lbit (lbit)
  );

  fpr_round_decide u_decide (
    .mode    (rnd_mode_e'(rnd_mode)),
    .sign    (in_sign),
    .rbit    (rbit),
    .sbit    (sbit),
    .lbit    (lbit),
    .do_inc  (do_inc),
    .inexact (inexact)
  );

  fpr_incr_norm #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_incr (
    .kept   (kept),
    .unit   (unit),
    .do_inc (do_inc),
    .exp_in (in_exp),
    .sig_o  (sig_n),
    .exp_o  (exp_n),
    .ovf    (ovf_n),
    .unf    (unf_n)
  );

  assign flags_n = '{inexact: inexact, rnd_up: do_inc, ovf: ovf_n, unf: unf_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_sig   <= '0;
      flags_q   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_sign  <= in_sign;
      out_exp   <= exp_n;
      out_sig   <= sig_n;
      flags_q   <= flags_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_inexact = flags_q.inexact;
  assign out_rnd_up  = flags_q.rnd_up;
  assign out_ovf     = flags_q.ovf;
  assign out_unf     = flags_q.unf;

endmodule

// File: rtl/fpr_round_unit_chk.sv
module fpr_round_unit_chk #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15,
  parameter int P_SGL = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_grd,
  input logic             in_rnd,
  input logic             in_stk,
  input logic [1:0]       rnd_mode,
  input logic [1:0]       prec_sel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [EXP_W-1:0] out_exp,
  input logic [SIG_W-1:0] out_sig,
  input logic             out_inexact,
  input logic             out_rnd_up,
  input logic             out_ovf,
  input logic             out_unf
);
  localparam int SGL_LOW = SIG_W - P_SGL;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sig) && $stable(out_exp)));

  p_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && prec_sel == 2'b00) |=> (out_sig[SGL_LOW-1:0] == '0));

  p_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rnd_mode == 2'b11) |=> !out_rnd_up);

  p_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && prec_sel == 2'b11 && !in_grd && !in_rnd && !in_stk)
      |=> !out_inexact);

  p_upinx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rnd_up) |-> out_inexact);

  p_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sig != '0) |-> out_sig[SIG_W-1]);

  p_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> ((&out_exp) && out_sig == {1'b1, {(SIG_W-1){1'b0}}}));

  p_unf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_exp == '0));

endmodule

bind fpr_round_unit fpr_round_unit_chk #(.SIG_W(SIG_W), .EXP_W(EXP_W), .P_SGL(P_SGL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_grd      (in_grd),
  .in_rnd      (in_rnd),
  .in_stk      (in_stk),
  .rnd_mode    (rnd_mode),
  .prec_sel    (prec_sel),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_exp     (out_exp),
  .out_sig     (out_sig),
  .out_inexact (out_inexact),
  .out_rnd_up  (out_rnd_up),
  .out_ovf     (out_ovf),
  .out_unf     (out_unf)
);

// File: tb/test_fpr_round_unit.sv
module test_fpr_round_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, in_sign, in_grd, in_rnd, in_stk;
  logic [14:0] in_exp;
  logic [63:0] in_sig;
  logic [1:0]  rnd_mode, prec_sel;
  logic        out_valid, out_ready, out_sign, out_inexact, out_rnd_up, out_ovf, out_unf;
  logic [14:0] out_exp;
  logic [63:0] out_sig;

  fpr_round_unit i_fpr_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_grd(in_grd),
    .in_rnd(in_rnd), .in_stk(in_stk), .rnd_mode(rnd_mode), .prec_sel(prec_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
    .out_exp(out_exp), .out_sig(out_sig), .out_inexact(out_inexact),
    .out_rnd_up(out_rnd_up), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  int checks = 0;
  int fails  = 0;
  logic [83:0] exp_q[$];
  string       tag_q[$];
  logic        mon_en = 1'b0;
  logic        bp_en  = 1'b0;

  function automatic logic [83:0] ref_round(input logic sg, input logic [14:0] ex,
      input logic [63:0] sv, input logic g, input logic r, input logic s,
      input logic [1:0] md, input logic [1:0] pr);
    int p, drop;
    logic [66:0] ext, rem, half;
    logic [64:0] kv;
    logic [14:0] eo;
    logic [63:0] so;
    logic up, inx, ovf, unf;
    p    = (pr == 2'b00) ? 24 : ((pr == 2'b10) ? 53 : 64);
    drop = 64 - p;
    ext  = {sv, g, r, s};
    rem  = ext & ((67'd1 << (drop + 3)) - 67'd1);
    half = 67'd1 << (drop + 2);
    kv   = 65'(sv >> drop);
    inx  = (rem != 67'd0);
    case (md)
      2'b00:   up = (rem > half) || (rem == half && kv[0]);
      2'b01:   up = sg && inx;
      2'b10:   up = !sg && inx;
      default: up = 1'b0;
    endcase
    eo  = ex;
    ovf = 1'b0;
    if (up) kv = kv + 65'd1;
    if (kv == (65'd1 << p)) begin
      kv  = 65'd1 << (p - 1);
      eo  = ex + 15'd1;
      ovf = (eo == 15'h7FFF);
    end
    so  = 64'(kv << drop);
    unf = (eo == 15'd0) && (so != 64'd0);
    return {sg, eo, so, inx, up, ovf, unf};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic send(input logic sg, input logic [14:0] ex, input logic [63:0] sv,
      input logic g, input logic r, input logic s, input logic [1:0] md,
      input logic [1:0] pr, input string tg);
    @(negedge clk);
    in_valid = 1'b1; in_sign = sg; in_exp = ex; in_sig = sv;
    in_grd = g; in_rnd = r; in_stk = s; rnd_mode = md; prec_sel = pr;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(ref_round(sg, ex, sv, g, r, s, md, pr));
    tag_q.push_back(tg);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Output consumer: ready changes shortly after each rising edge.
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor: compares against the model every cycle, away from the edge.
  logic        stalled = 1'b0;
  logic [83:0] saved;
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      logic [83:0] act, expv;
      string tg;
      act = {out_sign, out_exp, out_sig, out_inexact, out_rnd_up, out_ovf, out_unf};
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        fails++;
        $display("FAIL R1 in_ready act=%b exp=%b", in_ready, (!out_valid || out_ready));
      end
      if (stalled) begin
        checks++;
        if (!(out_valid && act == saved)) begin
          fails++;
          $display("FAIL R1 stalled output changed act=%h exp=%h", act, saved);
        end
      end
      stalled = out_valid && !out_ready;
      saved   = act;
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected result act=%h exp=none", act);
        end else begin
          expv = exp_q.pop_front();
          tg   = tag_q.pop_front();
          if (act !== expv) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tg, act, expv);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  localparam logic [63:0] TOP1 = 64'h8000_0000_0000_0000;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0; in_sig = '0;
    in_grd = 1'b0; in_rnd = 1'b0; in_stk = 1'b0; rnd_mode = 2'b00; prec_sel = 2'b11;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sig !== 64'd0 || out_exp !== 15'd0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset state act=%b/%h/%h exp=0/0/0", out_valid, out_sig, out_exp);
    end
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R3 nearest-even: tie even, tie odd, above half, below half
    send(0, 15'h3FFF, TOP1 | 64'h2, 1, 0, 0, 2'b00, 2'b11, "R3 tie even");
    send(0, 15'h3FFF, TOP1 | 64'h3, 1, 0, 0, 2'b00, 2'b11, "R3 tie odd");
    send(1, 15'h3FFF, TOP1 | 64'h2, 1, 0, 1, 2'b00, 2'b11, "R3 above half");
    send(0, 15'h3FFF, TOP1 | 64'h3, 0, 1, 1, 2'b00, 2'b11, "R3 below half");
    send(0, 15'h4000, 64'hC000_0080_0000_0000, 0, 0, 0, 2'b00, 2'b00, "R3 short tie even");
    // R4 directed modes
    send(1, 15'h3FFF, TOP1, 0, 0, 1, 2'b01, 2'b11, "R4 neg toward minus");
    send(0, 15'h3FFF, TOP1, 0, 0, 1, 2'b01, 2'b11, "R4 pos toward minus");
    send(0, 15'h3FFF, TOP1, 0, 0, 1, 2'b10, 2'b11, "R4 pos toward plus");
    send(1, 15'h3FFF, TOP1, 0, 0, 1, 2'b10, 2'b11, "R4 neg toward plus");
    send(0, 15'h3FFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, 2'b11, 2'b11, "R4 toward zero");
    send(1, 15'h3FFF, TOP1, 0, 0, 0, 2'b01, 2'b11, "R4 exact no step");
    // R2 precision codes, including the spare code
    send(0, 15'h1234, 64'h9ABC_DEF0_1234_5678, 1, 0, 1, 2'b10, 2'b00, "R2 short");
    send(0, 15'h1234, 64'h9ABC_DEF0_1234_5678, 1, 0, 1, 2'b10, 2'b10, "R2 medium");
    send(0, 15'h1234, 64'h9ABC_DEF0_1234_5678, 1, 0, 1, 2'b10, 2'b11, "R2 full");
    send(0, 15'h1234, 64'h9ABC_DEF0_1234_5678, 1, 0, 1, 2'b10, 2'b01, "R2 spare code");
    // R5 inexact from dropped significand bits only / exact
    send(0, 15'h2000, 64'hA5A5_A500_0000_0000, 0, 0, 0, 2'b00, 2'b00, "R5 exact short");
    send(0, 15'h2000, 64'hA5A5_A500_0000_0001, 0, 0, 0, 2'b00, 2'b00, "R5 lowest dropped bit");
    send(0, 15'h2000, 64'hA5A5_A5A5_A5A5_A5A5, 0, 0, 0, 2'b11, 2'b11, "R5 exact full");
    // R6/R7 carry renormalize
    send(0, 15'h3FFF, 64'hFFFF_FF80_0000_0000, 0, 0, 0, 2'b00, 2'b00, "R6 R7 short carry");
    send(1, 15'h3FFF, 64'hFFFF_FFFF_FFFF_F800, 0, 1, 0, 2'b01, 2'b10, "R7 medium carry");
    send(0, 15'h0100, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 2'b10, 2'b11, "R7 full carry");
    // R8 overflow together with carry
    send(0, 15'h7FFE, 64'hFFFF_FF80_0000_0000, 0, 0, 0, 2'b00, 2'b00, "R8 overflow short");
    send(1, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 2'b01, 2'b11, "R8 overflow full");
    send(0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 2'b11, 2'b11, "R8 no overflow trunc");
    // R9 underflow
    send(0, 15'h0000, TOP1 | 64'h55, 0, 1, 0, 2'b00, 2'b11, "R9 zero exponent");
    send(0, 15'h0000, 64'd0, 0, 0, 0, 2'b00, 2'b11, "R9 true zero");
    send(0, 15'h0001, TOP1, 0, 0, 0, 2'b00, 2'b11, "R9 smallest exponent");
    idle();

    // Back-pressure with random streams (R1, R10 sign, all modes)
    bp_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic [63:0] sv;
      logic [14:0] ex;
      sv = {1'b1, 31'($urandom), $urandom};
      if (($urandom % 4) == 0) sv = 64'hFFFF_FFFF_FFFF_FFFF ^ 64'($urandom % 4096);
      ex = 15'($urandom);
      if (($urandom % 8) == 0) ex = 15'h7FFE;
      if (ex == 15'h7FFF) ex = 15'h7FFD;
      send(1'($urandom), ex, sv, 1'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 2'($urandom), "R1 R3 R4 R10 stream");
      if (($urandom % 5) == 0) idle();
    end
    idle();
    bp_en = 1'b0;

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 results lost act=%0d pending exp=0", exp_q.size());
    end
    repeat (2) @(negedge clk);
    summary();
  end

endmodule